// File: doc/BRIEF.md
# Ed25519 Scalar Reducer

This block takes a 512-bit unsigned value, typically a hash digest, and returns its residue modulo the Ed25519 group order L = 2^252 + c, where c = 27742317777372353535851937790883648493 (a 125-bit constant). The result is a canonical 253-bit scalar in the range [0, L). A caller drives the value on `x_i` and pulses `start_i`. A fixed number of cycles later, `done_o` pulses and `result_o` carries the residue.

The reduction relies on the congruence 2^252 ≡ −c (mod L). Each fold splits the value into a high part and a low part and multiplies the high part by c. It then subtracts that product from the low part. The first fold splits at bit 256 and scales its product by 16. The second and third folds split at bit 252. All three folds always run. The multiply is a digit-serial product against the constant c, with a fixed number of steps. One final cycle adds L when the value is negative, or subtracts L when the value is at least L. Because of this, the latency does not depend on the data.

Top module: `ed_scalar_reduce`

## Requirements
- R1: After a start, `result_o` equals `x_i mod L`, where `x_i` is taken as an unsigned 512-bit number sampled in the start cycle.
- R2: Every result is canonical: 0 ≤ `result_o` < L. This holds for inputs equal to L, to exact multiples of L, just below or above a multiple, and for all-ones.
- R3: `done_o` goes high exactly 79 clock cycles after the rising edge that samples `start_i`, for every input value (default digit width of 5 bits).
- R4: `done_o` is high for exactly one cycle per accepted start.
- R5: `result_o` keeps its value in every cycle between two `done_o` pulses.
- R6: A `start_i` pulse while a reduction is in progress is ignored. The running job finishes at its original time with the result for its original input, and no extra `done_o` pulse follows.
- R7: In reset and directly after reset, `done_o` is 0 and `result_o` is 0.
- R8: `x_i` only needs to be valid in the start cycle. Changing it afterwards does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a reduction; sampled only while idle |
| x_i | input | 512 | Unsigned value to reduce |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | 253 | Canonical residue modulo L |

## Verification
Inputs of L, 2L, large exact multiples, L−1, L+1 and all-ones target the final correction step. A design that skips the add of L or the subtract of L returns a value shifted by L, or a non-canonical one. Values whose upper half is zero, or is 2^256 or 2^252 exactly, test whether the fold splits at the right bit and applies the factor of 16 only in the first fold. A wrong shift or split gives a wrong residue. A start pulse injected mid-job, and an input bus scrambled after the start cycle, show whether a design restarts, re-samples the input, or emits an extra or early completion pulse.

// File: rtl/scred_pkg.sv
// Package scred_pkg
// Shared sizes, constants and types for the Ed25519 scalar reducer.
// Assumes L = 2^SPLIT_B + FOLD_C, with FOLD_C < 2^SPLIT_B.
package scred_pkg;
    localparam int IN_W      = 512;                    // input width
    localparam int HALF_W    = IN_W / 2;               // first-fold split point
    localparam int SPLIT_B   = 252;                    // later-fold split point
    localparam int C_W       = 125;                    // width of the fold constant
    localparam logic [C_W-1:0] FOLD_C = 125'd27742317777372353535851937790883648493;
    localparam int OUT_W     = SPLIT_B + 1;            // canonical scalar width
    localparam int PRE_SHIFT = HALF_W - SPLIT_B;       // 2^256 = 2^4 * 2^252
    localparam int MA_W      = HALF_W + 1;             // signed multiplicand width
    localparam int PROD_W    = MA_W + C_W;             // signed product width
    localparam int WORK_W    = PROD_W + PRE_SHIFT + 2; // signed working width
    localparam int ROUNDS    = 3;                      // fixed fold count

    localparam logic [OUT_W-1:0] MOD_L = (OUT_W'(1) << SPLIT_B) | OUT_W'(FOLD_C);

    typedef logic signed [WORK_W-1:0] work_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MUL   = 2'd1,
        ST_FINAL = 2'd2
    } red_state_e;
endpackage

// File: rtl/scred_cmul.sv
// Module scred_cmul
// Digit-serial multiplier of a signed operand by a fixed unsigned constant.
// Walks the constant from its most significant digit, DIGIT_W bits per cycle,
// so every product takes exactly N_DIG cycles after start_i. done_o pulses
// for one cycle when prod_o is valid; prod_o holds until the next start.
// Assumes start_i is only raised while the unit is idle.
module scred_cmul #(
    parameter int A_W = 257,
    parameter int K_W = 125,
    parameter logic [K_W-1:0] K = '1,
    parameter int DIGIT_W = 5,
    localparam int P_W   = A_W + K_W,
    localparam int N_DIG = (K_W + DIGIT_W - 1) / DIGIT_W,
    localparam int PAD_W = N_DIG * DIGIT_W,
    localparam int CNT_W = $clog2(N_DIG + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic signed [A_W-1:0] a_i,
    output logic                  done_o,
    output logic signed [P_W-1:0] prod_o
);
    logic [PAD_W-1:0]      k_pad;
    logic signed [A_W-1:0] a_q;
    logic signed [P_W-1:0] acc_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  done_q;
    logic [DIGIT_W-1:0]    digit;
    logic signed [P_W-1:0] a_ext;
    logic signed [P_W-1:0] dig_ext;
    logic signed [P_W-1:0] part;
    int                    idx;

    assign k_pad = PAD_W'(K);

    // Select the current constant digit and form its partial product.
    always_comb begin
        idx     = (cnt_q == '0) ? 0 : (int'(cnt_q) - 1) * DIGIT_W;
        digit   = k_pad[idx +: DIGIT_W];
        a_ext   = P_W'(a_q);
        dig_ext = P_W'($signed({1'b0, digit}));
        part    = a_ext * dig_ext;
    end

    // Load on start, then shift-accumulate one digit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                a_q   <= a_i;
                acc_q <= '0;
                cnt_q <= CNT_W'(N_DIG);
            end else if (cnt_q != '0) begin
                acc_q <= (acc_q <<< DIGIT_W) + part;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign prod_o = acc_q;

    AST_MUL_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (cnt_q == '0)); // R6

    AST_MUL_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(1)) |=> done_o); // R3
endmodule

// File: rtl/scred_fold.sv
// Module scred_fold
// One combinational fold step: value = low - (prod << shift), where the shift
// is PRE_SHIFT in the first fold and zero afterwards. It also splits the
// result at SPLIT_B: the arithmetic high part feeds the next multiply, and the
// non-negative low part becomes the next fold's addend.
// Assumes prod_i is the signed product of the previous high part and FOLD_C.
module scred_fold
    import scred_pkg::*;
(
    input  logic [HALF_W-1:0]        low_i,
    input  logic signed [PROD_W-1:0] prod_i,
    input  logic                     pre_shift_i,
    output work_t                    value_o,
    output logic signed [MA_W-1:0]   hi_o,
    output logic [SPLIT_B-1:0]       lo_o
);
    work_t p_ext;
    work_t p_sh;
    work_t low_ext;
    work_t hi_full;

    // Subtract the scaled product from the low part and split the result.
    always_comb begin
        p_ext   = WORK_W'(prod_i);
        p_sh    = pre_shift_i ? (p_ext <<< PRE_SHIFT) : p_ext;
        low_ext = $signed(WORK_W'(low_i));
        value_o = low_ext - p_sh;
        hi_full = value_o >>> SPLIT_B;
        hi_o    = MA_W'(hi_full);
        lo_o    = value_o[SPLIT_B-1:0];
    end
endmodule

// File: rtl/scred_canon.sv
// Module scred_canon
// Final correction into [0, L). Adds L to a negative value, or subtracts L
// from a value that is at least L; otherwise passes the value through.
// Assumes -L <= v_i < 2L, which the three folds guarantee.
module scred_canon
    import scred_pkg::*;
(
    input  work_t            v_i,
    output logic [OUT_W-1:0] r_o
);
    localparam work_t MOD_L_W = $signed(WORK_W'(MOD_L));

    work_t plus_l;
    work_t minus_l;
    work_t sel;
    logic  unused_hi;

    // Pick one of v, v+L, v-L by sign and range.
    always_comb begin
        plus_l  = v_i + MOD_L_W;
        minus_l = v_i - MOD_L_W;
        if (v_i[WORK_W-1]) begin
            sel = plus_l;
        end else if (v_i >= MOD_L_W) begin
            sel = minus_l;
        end else begin
            sel = v_i;
        end
        r_o       = sel[OUT_W-1:0];
        unused_hi = ^sel[WORK_W-1:OUT_W];
    end
endmodule

// File: rtl/ed_scalar_reduce.sv
// Module ed_scalar_reduce
// Reduces a 512-bit unsigned value modulo L = 2^252 + FOLD_C in constant time.
// Always runs three folds on one shared digit-serial multiplier, then spends
// one cycle on the canonical correction. done_o pulses LATENCY cycles after
// the edge that accepts start_i. result_o holds until the next done_o.
// Assumes start_i is ignored outside the idle state.
module ed_scalar_reduce
    import scred_pkg::*;
#(
    parameter int DIGIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IN_W-1:0]   x_i,
    output logic              done_o,
    output logic [OUT_W-1:0]  result_o
);
    localparam int N_DIG      = (C_W + DIGIT_W - 1) / DIGIT_W;
    localparam int LATENCY    = ROUNDS * (N_DIG + 1) + 1;
    localparam int LAT_W      = $clog2(LATENCY + 2) + 1;
    localparam logic [1:0] LAST_ROUND = 2'(ROUNDS - 1);

    red_state_e               state_q;
    logic [1:0]               round_q;
    logic [HALF_W-1:0]        low_q;
    work_t                    fin_q;
    logic [OUT_W-1:0]         result_q;
    logic                     done_q;

    logic                     mul_start;
    logic signed [MA_W-1:0]   mul_a;
    logic                     mul_done;
    logic signed [PROD_W-1:0] mul_p;
    work_t                    fold_val;
    logic signed [MA_W-1:0]   fold_hi;
    logic [SPLIT_B-1:0]       fold_lo;
    logic [OUT_W-1:0]         canon_r;

    scred_cmul #(
        .A_W     (MA_W),
        .K_W     (C_W),
        .K       (FOLD_C),
        .DIGIT_W (DIGIT_W)
    ) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mul_start),
        .a_i     (mul_a),
        .done_o  (mul_done),
        .prod_o  (mul_p)
    );

    scred_fold u_fold (
        .low_i       (low_q),
        .prod_i      (mul_p),
        .pre_shift_i (round_q == 2'd0),
        .value_o     (fold_val),
        .hi_o        (fold_hi),
        .lo_o        (fold_lo)
    );

    scred_canon u_canon (
        .v_i (fin_q),
        .r_o (canon_r)
    );

    // Launch the multiplier: first from the input's upper half, then from each fold's high part.
    always_comb begin
        mul_start = 1'b0;
        mul_a     = fold_hi;
        if (state_q == ST_IDLE && start_i) begin
            mul_start = 1'b1;
            mul_a     = $signed({1'b0, x_i[IN_W-1:HALF_W]});
        end else if (state_q == ST_MUL && mul_done && round_q != LAST_ROUND) begin
            mul_start = 1'b1;
        end
    end

    // Sequence the three folds and the final correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            round_q  <= 2'd0;
            low_q    <= '0;
            fin_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        low_q   <= x_i[HALF_W-1:0];
                        round_q <= 2'd0;
                        state_q <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    if (mul_done) begin
                        if (round_q == LAST_ROUND) begin
                            fin_q   <= fold_val;
                            state_q <= ST_FINAL;
                        end else begin
                            low_q   <= HALF_W'(fold_lo);
                            round_q <= round_q + 2'd1;
                        end
                    end
                end
                ST_FINAL: begin
                    result_q <= canon_r;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o   = done_q;
    assign result_o = result_q;

    // Checker counter: cycles since the accepted start, saturating.
    logic [LAT_W-1:0] chk_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_cnt <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            chk_cnt <= LAT_W'(1);
        end else if (chk_cnt != '0 && chk_cnt != '1) begin
            chk_cnt <= chk_cnt + LAT_W'(1);
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (chk_cnt == LAT_W'(LATENCY + 1))); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4

    AST_RESULT_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o < MOD_L)); // R2

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(result_o))); // R5

    AST_LAST_FOLD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL && mul_done && round_q == LAST_ROUND)
        |-> ((fold_val[WORK_W-1:OUT_W] == '0) || (fold_val[WORK_W-1:OUT_W] == '1))); // R2
endmodule

// File: tb/tb_ed_scalar_reduce.sv
module tb_ed_scalar_reduce;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 79;
    localparam int WD_CYCLES  = 150000;
    localparam logic [511:0] L_B = (512'd1 << 252) + 512'd27742317777372353535851937790883648493;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [511:0] x_i;
    logic         done_o;
    logic [252:0] result_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    ed_scalar_reduce dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .x_i      (x_i),
        .done_o   (done_o),
        .result_o (result_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WD_CYCLES) begin
            n_bad = n_bad + 1;
            $display("FAIL R3 watchdog: cycles=%0d expected<=%0d", cyc, WD_CYCLES);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] rand512();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom();
        return r;
    endfunction

    // One reduction; optionally injects a start pulse while busy (R6).
    task automatic run_one(input logic [511:0] x, input bit inject);
        logic [252:0] exp;
        logic [252:0] held;
        int n;
        exp = 253'(x % L_B);
        @(negedge clk);
        x_i = x;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        x_i = ~x;                        // R8: scramble input after start
        n = 0;
        while (!done_o && n < 1000) begin
            if (inject && n == 10) begin
                start_i = 1'b1;
                x_i = rand512();
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            n = n + 1;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(n == LAT, inject ? "R3 R6 latency" : "R3 latency", 512'(n), 512'(LAT));
        check(result_o == exp, inject ? "R1 R6 R8 residue" : "R1 R8 residue", 512'(result_o), 512'(exp));
        check(512'(result_o) < L_B, "R2 canonical", 512'(result_o), L_B);
        held = result_o;
        @(negedge clk);
        check(done_o == 1'b0, "R4 single-cycle done", 512'(done_o), 512'd0);
        repeat (3) @(negedge clk);
        check(result_o == held && !done_o, inject ? "R5 R6 result held" : "R5 result held",
              512'(result_o), 512'(held));
    endtask

    initial begin
        void'($urandom(32'd7741));
        rst_n = 1'b0;
        start_i = 1'b0;
        x_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0 && result_o == '0, "R7 in reset", 512'(result_o), 512'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0 && result_o == '0, "R7 after reset", 512'(result_o), 512'd0);

        // Directed corners (R1, R2)
        run_one(512'd0, 1'b0);
        run_one(512'd1, 1'b0);
        run_one(L_B - 512'd1, 1'b0);
        run_one(L_B, 1'b0);
        run_one(L_B + 512'd1, 1'b0);
        run_one(L_B * 512'd2, 1'b0);
        run_one('1, 1'b0);
        run_one(512'd1 << 256, 1'b0);
        run_one(512'd1 << 252, 1'b0);
        run_one((512'd1 << 256) - 512'd1, 1'b0);
        run_one(L_B * ((512'd1 << 259) - 512'd1), 1'b0);
        run_one(L_B * ((512'd1 << 259) - 512'd1) + L_B - 512'd1, 1'b0);
        run_one(L_B * 512'd16, 1'b0);

        // Busy-start injection (R6)
        run_one(rand512(), 1'b1);
        run_one(L_B + 512'd5, 1'b1);

        // Constrained random: full width and narrowed upper parts
        for (int k = 0; k < 40; k++) begin
            logic [511:0] v;
            v = rand512();
            case (k % 4)
                1: v[511:256] = '0;
                2: v[511:300] = '0;
                3: v[511:500] = '1;
                default: ;
            endcase
            run_one(v, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule